// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is an accumulator-based arithmetic and logic unit. Each cycle with the write enable high, it takes a decoded operation code and one operand byte from a register or memory bus. It combines the operand with the accumulator, or in some cases uses the accumulator alone, and registers the result back into the accumulator. In the same edge it updates five status flags.

Instruction fetch, decoding and register-file or memory addressing sit outside the block. The surrounding datapath only presents `op_i`, `operand_i` and `we_i`. Immediate forms, such as an exclusive-or with a constant mask, arrive on the same operand bus as register operands.

Results and flags appear on `acc_o` and `flags_o` one clock edge after the operation is presented.

Top module: `acc_alu`

## Requirements
- R1: While `rst_ni` is low, asynchronously and independently of the clock, `acc_o` is 00h and every flag bit is 0.
- R2: The operation codes on `op_i` are: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 increment, 6 decrement, 7 rotate left circular, 8 complement. When `we_i` is low, or when `op_i` is 9..15, a clock edge leaves the accumulator and all flags unchanged.
- R3: Add stores (accumulator + operand) mod 256. Carry is the carry out of bit 7. Auxiliary carry is the carry out of bit 3. Adding the accumulator to itself doubles it.
- R4: Subtract stores (accumulator − operand) mod 256. Carry is set when the operand is greater than the accumulator, both taken as unsigned. Auxiliary carry is set when the operand's low nibble is greater than the accumulator's low nibble. For example, 97h − 65h gives 32h, and subtracting the accumulator from itself gives 00h.
- R5: AND, OR and XOR combine the accumulator bitwise with the operand and clear carry and auxiliary carry. XOR of the accumulator with itself gives 00h.
- R6: XOR with the operand F0h inverts bits 7..4 of the accumulator and keeps bits 3..0.
- R7: Increment and decrement add or subtract 1 with wrap-around. Carry keeps its previous value. Auxiliary carry is set on a carry out of bit 3 (increment) or a borrow into bit 3 (decrement).
- R8: Rotate left circular moves each bit up by one and bit 7 into bit 0. It copies the old bit 7 into carry and clears auxiliary carry. For example, A7h becomes 4Fh with carry 1.
- R9: Complement inverts every accumulator bit and clears carry and auxiliary carry.
- R10: After every executed operation, `flags_o` is {sign, zero, aux carry, parity, carry} from bit 4 down to bit 0. Sign is result bit 7. Zero is set when the result is 00h. Parity is set when the result has an even number of 1 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Execute the operation at the next edge |
| op_i | input | 4 | Decoded operation code |
| operand_i | input | DATA_W | Second operand or immediate byte |
| acc_o | output | DATA_W | Accumulator contents |
| flags_o | output | 5 | {sign, zero, aux carry, parity, carry} |

## Verification
The bench builds the unit with its defaults: an 8-bit accumulator with the auxiliary carry taken at the nibble boundary. At that width every worked value is reachable exactly, including the 97h − 65h difference, the A7h rotate, the F0h mask and the wrap between FFh and 00h. The nibble boundary at bit 4 lets single-step values such as 0Fh→10h and F0h−01h exercise the auxiliary carry and borrow directly.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_INC = 4'd5,
    OP_DEC = 4'd6,
    OP_RLC = 4'd7,
    OP_CPL = 4'd8
  } alu_op_e;

  localparam int FLG_W  = 5;
  localparam int FLG_CY = 0;
  localparam int FLG_P  = 1;
  localparam int FLG_AC = 2;
  localparam int FLG_Z  = 3;
  localparam int FLG_S  = 4;
endpackage

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
  import acc_alu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int AUX_BIT = 4
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o,
  output logic              ac_o,
  output logic              legal_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] b;
  logic [DATA_W:0]   sum_w, dif_w;
  logic [AUX_BIT:0]  lo_sum, lo_dif;

  always_comb begin
    b      = (op_i == OP_INC || op_i == OP_DEC) ? ONE : opnd_i;
    sum_w  = {1'b0, acc_i} + {1'b0, b};
    dif_w  = {1'b0, acc_i} - {1'b0, b};
    lo_sum = {1'b0, acc_i[AUX_BIT-1:0]} + {1'b0, b[AUX_BIT-1:0]};
    lo_dif = {1'b0, acc_i[AUX_BIT-1:0]} - {1'b0, b[AUX_BIT-1:0]};
    res_o   = acc_i;
    cy_o    = cy_i;
    ac_o    = 1'b0;
    legal_o = 1'b1;
    unique case (op_i)
      OP_ADD: begin res_o = sum_w[DATA_W-1:0]; cy_o = sum_w[DATA_W]; ac_o = lo_sum[AUX_BIT]; end
      OP_SUB: begin res_o = dif_w[DATA_W-1:0]; cy_o = dif_w[DATA_W]; ac_o = lo_dif[AUX_BIT]; end
      OP_AND: begin res_o = acc_i & opnd_i; cy_o = 1'b0; end
      OP_OR:  begin res_o = acc_i | opnd_i; cy_o = 1'b0; end
      OP_XOR: begin res_o = acc_i ^ opnd_i; cy_o = 1'b0; end
      OP_INC: begin res_o = sum_w[DATA_W-1:0]; ac_o = lo_sum[AUX_BIT]; end
      OP_DEC: begin res_o = dif_w[DATA_W-1:0]; ac_o = lo_dif[AUX_BIT]; end
      OP_RLC: begin res_o = {acc_i[DATA_W-2:0], acc_i[DATA_W-1]}; cy_o = acc_i[DATA_W-1]; end
      OP_CPL: begin res_o = ~acc_i; cy_o = 1'b0; end
      default: legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_alu_stat.sv
module acc_alu_stat #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] res_i,
  output logic              zero_o,
  output logic              sign_o,
  output logic              par_o
);
  logic [DATA_W:0] par_chain;

  assign par_chain[0] = 1'b1;  // even parity seed
  for (genvar i = 0; i < DATA_W; i++) begin : g_par
    assign par_chain[i+1] = par_chain[i] ^ res_i[i];
  end

  assign par_o  = par_chain[DATA_W];
  assign zero_o = ~|res_i;
  assign sign_o = res_i[DATA_W-1];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int AUX_BIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [FLG_W-1:0]  flags_o
);
  logic [DATA_W-1:0] acc_q, res;
  logic [FLG_W-1:0]  flg_q, flg_d;
  logic              cy_n, ac_n, legal, z_n, s_n, p_n;

  acc_alu_exec #(.DATA_W(DATA_W), .AUX_BIT(AUX_BIT)) u_exec (
    .op_i    (alu_op_e'(op_i)),
    .acc_i   (acc_q),
    .opnd_i  (operand_i),
    .cy_i    (flg_q[FLG_CY]),
    .res_o   (res),
    .cy_o    (cy_n),
    .ac_o    (ac_n),
    .legal_o (legal)
  );

  acc_alu_stat #(.DATA_W(DATA_W)) u_stat (
    .res_i  (res),
    .zero_o (z_n),
    .sign_o (s_n),
    .par_o  (p_n)
  );

  always_comb begin
    flg_d         = '0;
    flg_d[FLG_S]  = s_n;
    flg_d[FLG_Z]  = z_n;
    flg_d[FLG_AC] = ac_n;
    flg_d[FLG_P]  = p_n;
    flg_d[FLG_CY] = cy_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      flg_q <= '0;
    end else if (we_i && legal) begin
      acc_q <= res;
      flg_q <= flg_d;
    end
  end

  assign acc_o   = acc_q;
  assign flags_o = flg_q;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [DATA_W-1:0] acc_o,
  input logic [FLG_W-1:0]  flags_o
);
  always_comb begin
    if (!rst_ni) a_r1_reset_clear: assert (acc_o == '0 && flags_o == '0);
  end

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i || op_i > 4'd8) |=> ($stable(acc_o) && $stable(flags_o)));

  a_r3_add_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == OP_ADD) |=> acc_o == DATA_W'($past(acc_o) + $past(operand_i)));

  a_r4_sub_borrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == OP_SUB) |=> flags_o[FLG_CY] == ($past(operand_i) > $past(acc_o)));

  a_r5_logic_clears_cy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)) |=>
      (!flags_o[FLG_CY] && !flags_o[FLG_AC]));

  a_r7_cy_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (op_i == OP_INC || op_i == OP_DEC)) |=> $stable(flags_o[FLG_CY]));

  a_r8_rlc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == OP_RLC) |=>
      (acc_o == {$past(acc_o[DATA_W-2:0]), $past(acc_o[DATA_W-1])}
       && flags_o[FLG_CY] == $past(acc_o[DATA_W-1])));

  a_r10_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i <= 4'd8) |=> flags_o[FLG_Z] == (acc_o == '0));

  a_r10_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i <= 4'd8) |=> flags_o[FLG_S] == acc_o[DATA_W-1]);

  a_r10_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i <= 4'd8) |=> flags_o[FLG_P] == ($countones(acc_o) % 2 == 0));
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .op_i      (op_i),
  .operand_i (operand_i),
  .acc_o     (acc_o),
  .flags_o   (flags_o)
);

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we_i = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [7:0] operand_i = 8'h00;
  logic [7:0] acc_o;
  logic [4:0] flags_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_acc = 8'h00;
  logic [4:0] m_flg = 5'b0;

  typedef struct {logic [7:0] acc; logic [4:0] flg; string tag;} item_t;
  item_t q[$];

  acc_alu uut (.clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .op_i(op_i),
               .operand_i(operand_i), .acc_o(acc_o), .flags_o(flags_o));

  always #2.5 clk_i = ~clk_i;

  // reference model from the requirements; flags {S,Z,AC,P,CY}
  task automatic model(input logic [3:0] op, input logic [7:0] b, input logic we);
    logic [8:0] t;
    logic [7:0] r;
    logic cy, ac;
    r = m_acc; cy = m_flg[0]; ac = 1'b0;
    if (!we || op > 4'd8) return;
    case (op)
      4'd0: begin t = {1'b0, m_acc} + {1'b0, b}; r = t[7:0]; cy = t[8];
                  ac = ({1'b0, m_acc[3:0]} + {1'b0, b[3:0]}) > 5'd15; end
      4'd1: begin r = m_acc - b; cy = b > m_acc; ac = b[3:0] > m_acc[3:0]; end
      4'd2: begin r = m_acc & b; cy = 1'b0; end
      4'd3: begin r = m_acc | b; cy = 1'b0; end
      4'd4: begin r = m_acc ^ b; cy = 1'b0; end
      4'd5: begin r = m_acc + 8'd1; ac = (m_acc[3:0] == 4'hF); end
      4'd6: begin r = m_acc - 8'd1; ac = (m_acc[3:0] == 4'h0); end
      4'd7: begin r = {m_acc[6:0], m_acc[7]}; cy = m_acc[7]; end
      default: begin r = ~m_acc; cy = 1'b0; end
    endcase
    m_acc = r;
    m_flg = {r[7], r == 8'h00, ac, ($countones(r) % 2 == 0), cy};
  endtask

  task automatic apply(input logic [3:0] op, input logic [7:0] b, input logic we, input string tag);
    item_t it;
    @(negedge clk_i);
    op_i = op; operand_i = b; we_i = we;
    model(op, b, we);
    it.acc = m_acc; it.flg = m_flg; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expect_val(input logic [7:0] acc, input logic cy, input string tag);
    @(posedge clk_i); #1.5;
    checks++;
    if (acc_o !== acc || flags_o[0] !== cy) begin
      errors++;
      $display("FAIL %s: acc=%h cy=%b expected acc=%h cy=%b", tag, acc_o, flags_o[0], acc, cy);
    end
  endtask

  // scoreboard monitor
  initial begin
    item_t it;
    forever begin
      @(posedge clk_i);
      if (q.size() > 0) begin
        it = q.pop_front();
        #1;
        checks++;
        if (acc_o !== it.acc || flags_o !== it.flg) begin
          errors++;
          $display("FAIL %s: acc=%h flags=%b expected acc=%h flags=%b",
                   it.tag, acc_o, flags_o, it.acc, it.flg);
        end
      end
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3;
    checks++;
    if (acc_o !== 8'h00 || flags_o !== 5'b0) begin
      errors++;
      $display("FAIL R1: acc=%h flags=%b expected acc=00 flags=00000", acc_o, flags_o);
    end
    @(negedge clk_i); rst_ni = 1'b1;

    apply(4'd2, 8'h00, 1'b1, "R5 and clear");
    apply(4'd3, 8'h97, 1'b1, "R5 or load");
    apply(4'd1, 8'h65, 1'b1, "R4 sub 97-65"); expect_val(8'h32, 1'b0, "R4 sub 97-65");
    apply(4'd0, 8'h32, 1'b1, "R3 double");    expect_val(8'h64, 1'b0, "R3 double");
    apply(4'd4, 8'hF0, 1'b1, "R6 xor F0");    expect_val(8'h94, 1'b0, "R6 xor F0");
    apply(4'd4, 8'h94, 1'b1, "R5 xor self");  expect_val(8'h00, 1'b0, "R5 xor self");
    apply(4'd3, 8'hA7, 1'b1, "R10 or A7");
    apply(4'd7, 8'h00, 1'b1, "R8 rlc");       expect_val(8'h4F, 1'b1, "R8 rlc");
    apply(4'd1, 8'h4F, 1'b1, "R4 sub self");  expect_val(8'h00, 1'b0, "R4 sub self");
    apply(4'd3, 8'h10, 1'b1, "R5 or 10");
    apply(4'd1, 8'h20, 1'b1, "R4 borrow");    expect_val(8'hF0, 1'b1, "R4 borrow");
    apply(4'd1, 8'h01, 1'b1, "R4 nibble borrow");
    apply(4'd3, 8'hFF, 1'b1, "R5 or FF");
    apply(4'd0, 8'h01, 1'b1, "R3 wrap");      expect_val(8'h00, 1'b1, "R3 wrap");
    apply(4'd6, 8'h00, 1'b1, "R7 dec wrap");  expect_val(8'hFF, 1'b1, "R7 dec wrap");
    apply(4'd5, 8'h00, 1'b1, "R7 inc wrap");
    apply(4'd3, 8'h0F, 1'b1, "R5 or 0F");
    apply(4'd5, 8'h00, 1'b1, "R7 inc nibble");
    apply(4'd0, 8'h08, 1'b1, "R3 nibble carry");
    apply(4'd8, 8'h00, 1'b1, "R9 complement");
    apply(4'd0, 8'h55, 1'b0, "R2 we low");
    apply(4'd12, 8'h55, 1'b1, "R2 illegal op");
    apply(4'd2, 8'h03, 1'b1, "R10 parity");
    apply(4'd3, 8'h80, 1'b1, "R10 sign");
    apply(4'd0, 8'h00, 1'b0, "R2 idle");
    repeat (3) @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule